// File: doc/BRIEF.md
# Stepper Excitation Position Sequencer

This block turns an external step clock into the coil current targets for one two-winding stepper motor. It holds an electrical position counter. The counter moves by a mode-dependent amount on each rising edge of the step clock. From the counter the block derives two signed current percentages, one for each winding. Winding A follows the cosine of the electrical angle and winding B follows the sine. A downstream chopping regulator and reference generator turn these targets into coil currents.

The block supports five excitation modes: two-phase, full-torque half step, standard half step, and 256- or 128-division microstepping. Configuration arrives as a one-cycle load strobe that carries the mode, direction, hold, counter-reset and output-enable fields together. Output enable, hold and counter reset take effect at the strobe. Mode and direction wait for the next step edge, and a mode change re-aligns the position on that first step. Hold freezes the internal copy of the step clock at its current level. Output disable only raises a high-impedance flag, and the counter keeps running.

Top module: `stp_excite_seq`

## Requirements
- R1: After reset the position is 0°, so winding A reads +100 and winding B reads 0. The high-impedance flag is 1, the mode is standard half step, and the direction is forward.
- R2: All configuration fields are captured on a cycle with `cfg_load` high. From the next cycle `coil_hiz` equals the inverse of the captured `cfg_out_en`.
- R3: The position advances once per rising edge of `step_clk`. `step_clk` is sampled on `clk`, and holding it high for several cycles causes no further advance.
- R4: With `cfg_dir`=0 (forward) the angle increases, so winding B lags winding A by 90°. With `cfg_dir`=1 the angle decreases, so winding B leads.
- R5: A newly loaded mode or direction changes neither the position nor the current values until the next step edge.
- R6: The angle step per edge depends on `cfg_mode`: 0 (two-phase) is 90°, 1 (full-torque half step) and 2 (half step) are 45°, 3 is 360/256°, and 4 is twice that. Codes 5 to 7 act as 4.
- R7: With the angle θ equal to position×360/256, winding A is round(100·cos θ) and winding B is round(100·sin θ), each within ±1. In modes 0 and 1 every nonzero magnitude is raised to exactly 100.
- R8: Loading hold=1 freezes the internal step clock at its present level, so no step edge advances the position. After a load with hold=0, the position advances at the next rising edge of `step_clk`. A clock that is already high at that load is not an edge.
- R9: A load with `cfg_cnt_rst`=1 at once applies the loaded mode and direction and sets the initial position: 315° in mode 0 (A=+100, B=−100) and 0° in every other mode. While counter reset is active the position is frozen. After a load that clears it, the first step edge advances the position.
- R10: With output disabled, `coil_hiz` is 1 and the position still advances on step edges. Re-enabling shows the currents of the position that was reached.
- R11: On the first step after a change to mode 0, 1 or 2, the position moves to 45°. If it is already at 45°, it takes the new mode's normal step instead.
- R12: On the first step after a change to mode 3 or 4, the position moves one 1/256 step in the current direction. The exception is mode 4 from an even position, which moves two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_clk | input | 1 | Step clock, synchronous to `clk` |
| cfg_load | input | 1 | One-cycle strobe that captures all `cfg_*` fields |
| cfg_mode | input | 3 | Excitation mode code (see R6) |
| cfg_dir | input | 1 | 0 forward, 1 reverse |
| cfg_hold | input | 1 | 1 freezes the internal step clock |
| cfg_cnt_rst | input | 1 | 1 forces and holds the initial position |
| cfg_out_en | input | 1 | 1 drives the windings, 0 requests high impedance |
| coil_a_pct | output | 8 | Signed winding A current target, −100 to +100 |
| coil_b_pct | output | 8 | Signed winding B current target, −100 to +100 |
| coil_hiz | output | 1 | 1 when both windings are to be high impedance |

## Verification
The assertions assume that `step_clk` is synchronous to `clk` and keeps each level for at least one cycle. They also assume that a rising step edge never arrives in the same cycle as `cfg_load`, since the load takes priority and such an edge is dropped. The bench drives all inputs on falling clock edges and samples outputs there. Every load and every step-clock transition is separated by at least one clock cycle, so no stimulus relies on the collision case. Expected currents come from the bench's own trigonometry, with a ±1 tolerance, and the expected positions are worked out by hand for each scenario.

// File: rtl/stp_pkg.sv
package stp_pkg;

  localparam logic [2:0] MODE_2PH  = 3'd0;
  localparam logic [2:0] MODE_12FT = 3'd1;
  localparam logic [2:0] MODE_12   = 3'd2;
  localparam logic [2:0] MODE_M256 = 3'd3;
  localparam logic [2:0] MODE_M128 = 3'd4;

  // Codes above the last defined mode fold onto the coarse microstep mode.
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return (m > MODE_M128) ? MODE_M128 : m;
  endfunction

  function automatic logic is_coarse(input logic [2:0] m);
    return (m == MODE_2PH) || (m == MODE_12FT) || (m == MODE_12);
  endfunction

  function automatic logic is_full_torque(input logic [2:0] m);
    return (m == MODE_2PH) || (m == MODE_12FT);
  endfunction

  // Rational sine approximation over a half period of 'half' steps,
  // scaled to 'full' and rounded to nearest.
  function automatic int sine_pct(input int a, input int half, input int full);
    longint num;
    longint den;
    num = 64'(16) * a * (half - a) * full;
    den = 64'(5) * half * half - 64'(4) * a * (half - a);
    return int'((2 * num + den) / (2 * den));
  endfunction

endpackage

// File: rtl/stp_step_gate.sv
module stp_step_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic step_clk,
  input  logic cfg_load,
  input  logic cfg_hold,
  output logic step_edge
);

  logic hold_r, hold_n;
  logic lvl_r, lvl_n;
  logic prev_r, prev_n;
  logic int_clk;

  assign int_clk   = hold_r ? lvl_r : step_clk;
  assign step_edge = int_clk & ~prev_r & ~cfg_load;

  always_comb begin
    hold_n = hold_r;
    lvl_n  = lvl_r;
    prev_n = int_clk;
    if (cfg_load) begin
      hold_n = cfg_hold;
      lvl_n  = int_clk;
      // On release, start from the live level so a high clock is no edge.
      prev_n = cfg_hold ? int_clk : step_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_r <= 1'b0;
      lvl_r  <= 1'b0;
      prev_r <= 1'b0;
    end else begin
      hold_r <= hold_n;
      lvl_r  <= lvl_n;
      prev_r <= prev_n;
    end
  end

  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_r |-> !step_edge);

  p_release_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !cfg_hold) |=> (!step_edge || $rose(step_clk)));

endmodule

// File: rtl/stp_pos_ctrl.sv
module stp_pos_ctrl
  import stp_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_edge,
  input  logic             cfg_load,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_dir,
  input  logic             cfg_cnt_rst,
  output logic [POS_W-1:0] pos,
  output logic [2:0]       cur_mode
);

  localparam int QTR = 1 << (POS_W - 2);
  localparam logic [POS_W-1:0] EIGHTH   = POS_W'(QTR / 2);
  localparam logic [POS_W-1:0] INIT_2PH = POS_W'((1 << POS_W) - QTR / 2);

  logic [POS_W-1:0] pos_r, pos_n;
  logic [2:0]       cur_mode_r, cur_mode_n;
  logic [2:0]       pend_mode_r, pend_mode_n;
  logic             pend_dir_r, pend_dir_n;
  logic             crst_r, crst_n;
  logic [2:0]       mode_in;
  logic             jump;
  logic [POS_W-1:0] amt;
  logic [POS_W-1:0] stepped;
  logic             advance;

  function automatic logic [POS_W-1:0] step_size(input logic [2:0] m);
    case (m)
      MODE_2PH:  return POS_W'(QTR);
      MODE_12FT,
      MODE_12:   return POS_W'(QTR / 2);
      MODE_M256: return POS_W'(1);
      default:   return POS_W'(2);
    endcase
  endfunction

  assign mode_in = norm_mode(cfg_mode);
  assign advance = step_edge & ~crst_r & ~cfg_load;

  always_comb begin
    jump = 1'b0;
    amt  = step_size(pend_mode_r);
    if (pend_mode_r != cur_mode_r) begin
      if (is_coarse(pend_mode_r)) begin
        jump = (pos_r != EIGHTH);
      end else if ((pend_mode_r == MODE_M256) || pos_r[0]) begin
        amt = POS_W'(1);
      end
    end
    if (jump)            stepped = EIGHTH;
    else if (pend_dir_r) stepped = pos_r - amt;
    else                 stepped = pos_r + amt;
  end

  always_comb begin
    pos_n       = pos_r;
    cur_mode_n  = cur_mode_r;
    pend_mode_n = pend_mode_r;
    pend_dir_n  = pend_dir_r;
    crst_n      = crst_r;
    if (cfg_load) begin
      pend_mode_n = mode_in;
      pend_dir_n  = cfg_dir;
      crst_n      = cfg_cnt_rst;
      if (cfg_cnt_rst) begin
        cur_mode_n = mode_in;
        pos_n      = (mode_in == MODE_2PH) ? INIT_2PH : '0;
      end
    end else if (advance) begin
      cur_mode_n = pend_mode_r;
      pos_n      = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_r       <= '0;
      cur_mode_r  <= MODE_12;
      pend_mode_r <= MODE_12;
      pend_dir_r  <= 1'b0;
      crst_r      <= 1'b0;
    end else begin
      pos_r       <= pos_n;
      cur_mode_r  <= cur_mode_n;
      pend_mode_r <= pend_mode_n;
      pend_dir_r  <= pend_dir_n;
      crst_r      <= crst_n;
    end
  end

  assign pos      = pos_r;
  assign cur_mode = cur_mode_r;

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_edge && !cfg_load) |=> $stable(pos_r));

  p_reset_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (crst_r && !cfg_load) |=> $stable(pos_r));

  p_micro_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_edge && !cfg_load && !crst_r && (pend_mode_r == cur_mode_r) &&
     (cur_mode_r == MODE_M256) && !pend_dir_r)
    |=> (pos_r == POS_W'($past(pos_r) + 1'b1)));

  p_realign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_edge && !cfg_load && !crst_r && (pend_mode_r != cur_mode_r) &&
     is_coarse(pend_mode_r) && (pos_r != EIGHTH))
    |=> (pos_r == EIGHTH));

endmodule

// File: rtl/stp_wave_fold.sv
module stp_wave_fold #(
  parameter int POS_W    = 8,
  parameter int PCT_W    = 8,
  parameter int FULL_PCT = 100
) (
  input  logic [POS_W-1:0]  angle,
  input  logic              full_torque,
  output logic signed [PCT_W-1:0] pct
);

  localparam int QTR = 1 << (POS_W - 2);

  logic [PCT_W-1:0] lut [QTR+1];
  logic [1:0]       quad;
  logic [POS_W-2:0] off;
  logic [POS_W-2:0] idx;
  logic [PCT_W-1:0] mag;

  for (genvar g = 0; g <= QTR; g++) begin : g_lut
    assign lut[g] = PCT_W'(stp_pkg::sine_pct(g, 2 * QTR, FULL_PCT));
  end

  assign quad = angle[POS_W-1:POS_W-2];
  assign off  = {1'b0, angle[POS_W-3:0]};

  always_comb begin
    idx = quad[0] ? ((POS_W-1)'(QTR) - off) : off;
    mag = lut[idx];
    if (full_torque && (mag != '0)) mag = PCT_W'(FULL_PCT);
    pct = quad[1] ? -$signed(mag) : $signed(mag);
  end

endmodule

// File: rtl/stp_excite_seq.sv
module stp_excite_seq
  import stp_pkg::*;
#(
  parameter int POS_W    = 8,
  parameter int PCT_W    = 8,
  parameter int FULL_PCT = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_clk,
  input  logic                    cfg_load,
  input  logic [2:0]              cfg_mode,
  input  logic                    cfg_dir,
  input  logic                    cfg_hold,
  input  logic                    cfg_cnt_rst,
  input  logic                    cfg_out_en,
  output logic signed [PCT_W-1:0] coil_a_pct,
  output logic signed [PCT_W-1:0] coil_b_pct,
  output logic                    coil_hiz
);

  localparam int QTR = 1 << (POS_W - 2);

  logic                    step_edge;
  logic [POS_W-1:0]        pos;
  logic [2:0]              cur_mode;
  logic                    full_torque;
  logic                    oe_r, oe_n;
  logic signed [PCT_W-1:0] wave [2];

  stp_step_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_clk  (step_clk),
    .cfg_load  (cfg_load),
    .cfg_hold  (cfg_hold),
    .step_edge (step_edge)
  );

  stp_pos_ctrl #(.POS_W(POS_W)) u_pos (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_edge   (step_edge),
    .cfg_load    (cfg_load),
    .cfg_mode    (cfg_mode),
    .cfg_dir     (cfg_dir),
    .cfg_cnt_rst (cfg_cnt_rst),
    .pos         (pos),
    .cur_mode    (cur_mode)
  );

  assign full_torque = is_full_torque(cur_mode);

  // Winding 0 (A) is the sine shifted a quarter turn ahead, winding 1 (B) the sine.
  for (genvar w = 0; w < 2; w++) begin : g_wind
    localparam logic [POS_W-1:0] SHIFT = (w == 0) ? POS_W'(QTR) : '0;
    stp_wave_fold #(.POS_W(POS_W), .PCT_W(PCT_W), .FULL_PCT(FULL_PCT)) u_fold (
      .angle       (pos + SHIFT),
      .full_torque (full_torque),
      .pct         (wave[w])
    );
  end

  assign oe_n = cfg_load ? cfg_out_en : oe_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_r <= 1'b0;
    else        oe_r <= oe_n;
  end

  assign coil_a_pct = wave[0];
  assign coil_b_pct = wave[1];
  assign coil_hiz   = ~oe_r;

  p_hiz_follows_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (coil_hiz == !$past(cfg_out_en)));

  p_mag_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_a_pct <= PCT_W'(FULL_PCT)) && (coil_a_pct >= -PCT_W'(FULL_PCT)) &&
    (coil_b_pct <= PCT_W'(FULL_PCT)) && (coil_b_pct >= -PCT_W'(FULL_PCT)));

  p_ft_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_torque |->
      ((coil_a_pct == 0) || (coil_a_pct == PCT_W'(FULL_PCT)) || (coil_a_pct == -PCT_W'(FULL_PCT))) &&
      ((coil_b_pct == 0) || (coil_b_pct == PCT_W'(FULL_PCT)) || (coil_b_pct == -PCT_W'(FULL_PCT))));

  p_oe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(coil_hiz));

endmodule

// File: tb/stp_excite_seq_test.sv
module stp_excite_seq_test;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_clk = 1'b0;
  logic cfg_load = 1'b0;
  logic [2:0] cfg_mode = 3'd2;
  logic cfg_dir = 1'b0;
  logic cfg_hold = 1'b0;
  logic cfg_cnt_rst = 1'b0;
  logic cfg_out_en = 1'b0;
  logic signed [7:0] coil_a_pct;
  logic signed [7:0] coil_b_pct;
  logic coil_hiz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stp_excite_seq uut (
    .clk (clk), .rst_n (rst_n), .step_clk (step_clk), .cfg_load (cfg_load),
    .cfg_mode (cfg_mode), .cfg_dir (cfg_dir), .cfg_hold (cfg_hold),
    .cfg_cnt_rst (cfg_cnt_rst), .cfg_out_en (cfg_out_en),
    .coil_a_pct (coil_a_pct), .coil_b_pct (coil_b_pct), .coil_hiz (coil_hiz)
  );

  function automatic int exp_pct(int p, bit ft, bit use_sin);
    real ang, v;
    ang = 2.0 * 3.14159265358979 * p / 256.0;
    v = 100.0 * (use_sin ? $sin(ang) : $cos(ang));
    if (ft) begin
      if (v > 0.5) return 100;
      if (v < -0.5) return -100;
      return 0;
    end
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  task automatic check_pos(int p, bit ft, string req);
    int ea, eb, da, db;
    ea = exp_pct(p, ft, 1'b0);
    eb = exp_pct(p, ft, 1'b1);
    da = int'(coil_a_pct) - ea;
    db = int'(coil_b_pct) - eb;
    checks++;
    if (da > 1 || da < -1 || db > 1 || db < -1) begin
      errors++;
      $display("FAIL %s position %0d: actual A=%0d B=%0d expected A=%0d B=%0d",
               req, p, coil_a_pct, coil_b_pct, ea, eb);
    end
  endtask

  task automatic check_hiz(bit e, string req);
    checks++;
    if (coil_hiz !== e) begin
      errors++;
      $display("FAIL %s hiz: actual %0b expected %0b", req, coil_hiz, e);
    end
  endtask

  task automatic load(logic [2:0] m, bit d, bit h, bit cr, bit oe);
    @(negedge clk);
    cfg_mode = m; cfg_dir = d; cfg_hold = h; cfg_cnt_rst = cr; cfg_out_en = oe;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic step(int hi_cycles);
    @(negedge clk);
    step_clk = 1'b1;
    repeat (hi_cycles) @(negedge clk);
    step_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_clk(bit v);
    @(negedge clk);
    step_clk = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check_pos(0, 1'b0, "R1");
    check_hiz(1'b1, "R1");
  endtask

  task automatic t_enable();
    load(3'd2, 1'b0, 1'b0, 1'b0, 1'b1);
    check_hiz(1'b0, "R2");
    check_pos(0, 1'b0, "R2");
  endtask

  task automatic t_forward();
    step(3);                       // long high level: one advance only
    check_pos(32, 1'b0, "R3");
    step(1);
    check_pos(64, 1'b0, "R4 forward lag");
  endtask

  task automatic t_reverse();
    load(3'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    check_pos(64, 1'b0, "R5 direction pending");
    step(1);
    check_pos(32, 1'b0, "R4 reverse");
    step(1);
    check_pos(0, 1'b0, "R4 reverse");
  endtask

  task automatic t_counter_reset();
    load(3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    check_pos(224, 1'b1, "R9 initial two-phase");
    step(1);
    check_pos(224, 1'b1, "R9 frozen");
    load(3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check_pos(224, 1'b1, "R9 release");
    step(1);
    check_pos(32, 1'b1, "R9 first advance");
    step(1);
    check_pos(96, 1'b1, "R6 two-phase 90 deg");
  endtask

  task automatic t_micro();
    load(3'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    check_pos(96, 1'b1, "R5 mode pending");
    step(1);
    check_pos(97, 1'b0, "R12 to 256-div");
    step(1);
    check_pos(98, 1'b0, "R6 256-div");
    load(3'd4, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1);
    check_pos(100, 1'b0, "R12 to 128-div even");
    step(1);
    check_pos(102, 1'b0, "R6 128-div");
  endtask

  task automatic t_coarse();
    load(3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1);
    check_pos(32, 1'b1, "R11 realign");
    step(1);
    check_pos(64, 1'b1, "R7 full torque");
    load(3'd2, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1);
    check_pos(32, 1'b0, "R11 realign half step");
    load(3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1);
    check_pos(64, 1'b1, "R11 already at 45 deg");
  endtask

  task automatic t_hold();
    set_clk(1'b1);
    check_pos(96, 1'b1, "R3");
    load(3'd1, 1'b0, 1'b1, 1'b0, 1'b1);    // held high
    set_clk(1'b0); set_clk(1'b1); set_clk(1'b0); set_clk(1'b1);
    check_pos(96, 1'b1, "R8 held high");
    load(3'd1, 1'b0, 1'b0, 1'b0, 1'b1);    // clear with clock high
    check_pos(96, 1'b1, "R8 no edge at clear");
    set_clk(1'b0); set_clk(1'b1);
    check_pos(128, 1'b1, "R8 advance after clear");
    set_clk(1'b0);
    load(3'd1, 1'b0, 1'b1, 1'b0, 1'b1);    // held low
    set_clk(1'b1); set_clk(1'b0); set_clk(1'b1);
    check_pos(128, 1'b1, "R8 held low");
    load(3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    check_pos(128, 1'b1, "R8 clear with clock high");
    set_clk(1'b0); set_clk(1'b1); set_clk(1'b0);
    check_pos(160, 1'b1, "R8 advance after clear");
  endtask

  task automatic t_out_off();
    load(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    check_hiz(1'b1, "R10 off");
    step(1);
    step(1);
    check_hiz(1'b1, "R10 off");
    load(3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    check_hiz(1'b0, "R10 on");
    check_pos(224, 1'b1, "R10 reached position");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R3: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_forward();
    t_reverse();
    t_counter_reset();
    t_micro();
    t_coarse();
    t_hold();
    t_out_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule